// File: doc/BRIEF.md
# SMBus Master Transaction Sequencer

This block takes one complete SMBus request and walks a downstream I2C byte engine through the byte-level steps that the request needs. A request carries an operation code, a 7-bit target address, a command byte, up to two data bytes and a block length. The sequencer turns it into a series of engine operations: start with an address byte, send byte, receive byte, NACK and stop. It issues one operation at a time and waits for the engine to finish each one before it issues the next.

Block transfers go through a 32-entry byte buffer. The host fills the buffer through a write port before a block write. The sequencer fills it during a block read, and the host reads the received bytes back through a separate read port. When the stop has completed, a one-cycle done pulse is raised. The error flag, the received byte or word, and the block count are valid from that pulse and stay unchanged until the next request is accepted.

Bus timing at bit level and packet error checking are handled elsewhere. The engine below the sequencer owns the wires.

Top module: `smbus_seq`

## Requirements
- R1: A request is accepted only in a cycle where `busy` is low. `busy` rises in the cycle after acceptance. Any `req_valid` seen while `busy` is high is ignored. Operation codes are: 0 quick, 1 send byte, 2 receive byte, 3 write byte, 4 write word, 5 read byte, 6 read word, 7 block write, 8 block read.
- R2: Engine operation codes are START=0, SEND=1, RECV=2, NACK=3, STOP=4. For a START, `eng_wbyte` is {address, rw}, where rw=1 means read. `eng_valid` is high for exactly one cycle per operation. No new operation is issued until `eng_done` returns for the previous one.
- R3: Quick command is START carrying `req_rd` as the direction, followed by STOP. No data byte is sent.
- R4: Send byte is START(write), SEND of `req_data[7:0]`, STOP. Receive byte is START(read), RECV, NACK, STOP, and the received byte appears on `rd_data[7:0]` with the upper byte at zero.
- R5: Write byte is START(write), SEND command, SEND `req_data[7:0]`, STOP. Write word sends `req_data[15:8]` after the low byte and before STOP.
- R6: Read byte and read word are START(write), SEND command, START(read), then one or two RECVs, NACK and STOP. The first received byte lands in `rd_data[7:0]` and the second in `rd_data[15:8]`.
- R7: Block write is START(write), SEND command, SEND count, then SEND of buffer entries 0 to count-1, then STOP. The count is `req_len`, clamped to 32. A count of zero goes straight to STOP.
- R8: Block read is START(write), SEND command, START(read), then a RECV whose byte is the count. A count above 32 is taken as zero. Then come that many RECVs, stored to buffer entries 0 onward, then NACK and STOP. The count is reported on `rd_len`.
- R9: If `eng_nak` is set on a completed START or SEND, the next operation is STOP and `err` is reported. `eng_nak` on a completed RECV has no effect.
- R10: `done` is a one-cycle pulse in the cycle after the final STOP completes. `busy` is low from the cycle after `done`. `err`, `rd_data` and `rd_len` hold their values until the next acceptance.
- R11: Operation codes 9 to 15 issue no engine operation. `done` comes in the cycle after acceptance, with `err` set.
- R12: Host writes to the buffer take effect only while `busy` is low. Writes made while `busy` is high are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 4 | Operation code |
| req_rd | input | 1 | Direction of a quick command (1 = read) |
| req_addr | input | 7 | Target address |
| req_cmd | input | 8 | Command byte |
| req_data | input | 16 | Write data, low byte first on the bus |
| req_len | input | LEN_W (8) | Requested block write length |
| buf_we | input | 1 | Host buffer write enable |
| buf_widx | input | AW (5) | Host buffer write index |
| buf_wdata | input | 8 | Host buffer write data |
| buf_ridx | input | AW (5) | Host buffer read index |
| buf_rdata | output | 8 | Host buffer read data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Transaction aborted or code invalid |
| rd_data | output | 16 | Received byte or word |
| rd_len | output | CW (6) | Block read count |
| eng_valid | output | 1 | Engine operation strobe |
| eng_op | output | 3 | Engine operation code |
| eng_wbyte | output | 8 | Address or data byte for the engine |
| eng_done | input | 1 | Engine operation finished |
| eng_nak | input | 1 | Byte was not acknowledged |
| eng_rbyte | input | 8 | Byte received by the engine |

## Verification
The bench goes after the edges of the length rules: a block write request of 40 must go out as 32 bytes, a request of 0 must send a zero count and stop, and received counts of 32 and 33 must give a full read and no read. A design that leaves the clamp out sends extra bytes, and one that compares off by one reads 33 bytes or rejects 32. NACKs are placed on the address, on a mid-word data byte and on a received byte. A design that ignores them keeps going after a refused byte, and one that honours a NACK on a RECV ends a good read with a false error. Buffer writes and requests made during a long block write check that neither the byte stream nor the sequence is disturbed. A word read with distinct bytes exposes swapped byte order.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

  typedef enum logic [2:0] {
    ENG_START = 3'd0,
    ENG_SEND  = 3'd1,
    ENG_RECV  = 3'd2,
    ENG_NACK  = 3'd3,
    ENG_STOP  = 3'd4
  } eng_op_e;

  typedef enum logic [3:0] {
    SM_QUICK = 4'd0,
    SM_SEND  = 4'd1,
    SM_RECV  = 4'd2,
    SM_WRB   = 4'd3,
    SM_WRW   = 4'd4,
    SM_RDB   = 4'd5,
    SM_RDW   = 4'd6,
    SM_BLKW  = 4'd7,
    SM_BLKR  = 4'd8
  } sm_op_e;

  localparam logic [3:0] SM_LAST = 4'd8;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_WR,
    PH_RSTART,
    PH_RXCNT,
    PH_RX,
    PH_NACK,
    PH_STOP,
    PH_DONE
  } phase_e;

endpackage

// File: rtl/smbus_seq_route.sv
module smbus_seq_route
  import smbus_seq_pkg::*;
(
  input  phase_e ph,
  input  sm_op_e op,
  input  logic   nak,
  input  logic   last_wr,
  input  logic   last_rx,
  input  logic   len_zero,
  input  logic   cnt_zero,
  output phase_e nxt,
  output logic   abort
);

  always_comb begin
    nxt   = PH_IDLE;
    abort = 1'b0;
    case (ph)
      PH_ADDR: begin
        if (nak) begin
          nxt = PH_STOP; abort = 1'b1;
        end else begin
          case (op)
            SM_QUICK: nxt = PH_STOP;
            SM_SEND:  nxt = PH_WR;
            SM_RECV:  nxt = PH_RX;
            default:  nxt = PH_CMD;
          endcase
        end
      end
      PH_CMD: begin
        if (nak) begin
          nxt = PH_STOP; abort = 1'b1;
        end else begin
          case (op)
            SM_WRB, SM_WRW: nxt = PH_WR;
            SM_BLKW:        nxt = PH_CNT;
            default:        nxt = PH_RSTART;
          endcase
        end
      end
      PH_CNT: begin
        if (nak) begin
          nxt = PH_STOP; abort = 1'b1;
        end else begin
          nxt = len_zero ? PH_STOP : PH_WR;
        end
      end
      PH_WR: begin
        if (nak) begin
          nxt = PH_STOP; abort = 1'b1;
        end else begin
          nxt = last_wr ? PH_STOP : PH_WR;
        end
      end
      PH_RSTART: begin
        if (nak) begin
          nxt = PH_STOP; abort = 1'b1;
        end else begin
          nxt = (op == SM_BLKR) ? PH_RXCNT : PH_RX;
        end
      end
      PH_RXCNT: nxt = cnt_zero ? PH_NACK : PH_RX;
      PH_RX:    nxt = last_rx ? PH_NACK : PH_RX;
      PH_NACK:  nxt = PH_STOP;
      PH_STOP:  nxt = PH_DONE;
      default:  nxt = PH_IDLE;
    endcase
  end

endmodule

// File: rtl/smbus_seq_buf.sv
module smbus_seq_buf #(
  parameter  int DEPTH = 32,
  parameter  int DW    = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);

  logic [DW-1:0] ent_arr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [DW-1:0] ent_q;
    logic          ent_en;
    assign ent_en = we && (waddr == AW'(g));
    always_ff @(posedge clk) begin
      if (ent_en) ent_q <= wdata;
    end
    assign ent_arr[g] = ent_q;
  end

  assign ra_data = ent_arr[ra_addr];
  assign rb_data = ent_arr[rb_addr];

endmodule

// File: rtl/smbus_seq.sv
module smbus_seq
  import smbus_seq_pkg::*;
#(
  parameter  int BUF_DEPTH = 32,
  parameter  int LEN_W     = 8,
  localparam int AW        = $clog2(BUF_DEPTH),
  localparam int CW        = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [3:0]       req_op,
  input  logic             req_rd,
  input  logic [6:0]       req_addr,
  input  logic [7:0]       req_cmd,
  input  logic [15:0]      req_data,
  input  logic [LEN_W-1:0] req_len,
  input  logic             buf_we,
  input  logic [AW-1:0]    buf_widx,
  input  logic [7:0]       buf_wdata,
  input  logic [AW-1:0]    buf_ridx,
  output logic [7:0]       buf_rdata,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [15:0]      rd_data,
  output logic [CW-1:0]    rd_len,
  output logic             eng_valid,
  output logic [2:0]       eng_op,
  output logic [7:0]       eng_wbyte,
  input  logic             eng_done,
  input  logic             eng_nak,
  input  logic [7:0]       eng_rbyte
);

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  phase_e          ph_q, ph_d, nxt;
  sm_op_e          op_q, op_d;
  logic            wait_q, wait_d;
  logic            rd_q, rd_d;
  logic [6:0]      addr_q, addr_d;
  logic [7:0]      cmd_q, cmd_d;
  logic [15:0]     dat_q, dat_d;
  logic [CW-1:0]   len_q, len_d;
  logic [CW-1:0]   idx_q, idx_d;
  logic            err_q, err_d;
  logic [15:0]     rdd_q, rdd_d;
  logic [CW-1:0]   rln_q, rln_d;
  logic            abort, step;
  logic [CW-1:0]   wr_total, rx_total, rcnt;
  logic            last_wr, last_rx;
  logic            seq_we, host_we, mem_we;
  logic [AW-1:0]   mem_waddr;
  logic [7:0]      mem_wdata, blk_byte;
  eng_op_e         eng_op_w;

  assign step = wait_q && eng_done;
  assign rcnt = (eng_rbyte > 8'(BUF_DEPTH)) ? '0 : CW'(eng_rbyte);

  always_comb begin
    case (op_q)
      SM_WRW:  wr_total = CW'(2);
      SM_BLKW: wr_total = len_q;
      default: wr_total = CW'(1);
    endcase
    case (op_q)
      SM_RDW:  rx_total = CW'(2);
      SM_BLKR: rx_total = rln_q;
      default: rx_total = CW'(1);
    endcase
  end
  assign last_wr = (idx_q == wr_total - CW'(1));
  assign last_rx = (idx_q == rx_total - CW'(1));

  smbus_seq_route u_route (
    .ph       (ph_q),
    .op       (op_q),
    .nak      (eng_nak),
    .last_wr  (last_wr),
    .last_rx  (last_rx),
    .len_zero (len_q == '0),
    .cnt_zero (rcnt == '0),
    .nxt      (nxt),
    .abort    (abort)
  );

  // next state
  always_comb begin
    ph_d = ph_q;   op_d = op_q;   wait_d = wait_q; rd_d = rd_q;
    addr_d = addr_q; cmd_d = cmd_q; dat_d = dat_q; len_d = len_q;
    idx_d = idx_q; err_d = err_q; rdd_d = rdd_q; rln_d = rln_q;
    case (ph_q)
      PH_IDLE: begin
        if (req_valid) begin
          rd_d   = req_rd;
          addr_d = req_addr;
          cmd_d  = req_cmd;
          dat_d  = req_data;
          len_d  = (req_len > LEN_W'(BUF_DEPTH)) ? CW'(BUF_DEPTH) : CW'(req_len);
          idx_d  = '0;
          wait_d = 1'b0;
          rdd_d  = '0;
          rln_d  = '0;
          if (req_op <= SM_LAST) begin
            op_d  = sm_op_e'(req_op);
            ph_d  = PH_ADDR;
            err_d = 1'b0;
          end else begin
            op_d  = SM_QUICK;
            ph_d  = PH_DONE;
            err_d = 1'b1;
          end
        end
      end
      PH_DONE: ph_d = PH_IDLE;
      default: begin
        if (!wait_q) begin
          wait_d = 1'b1;
        end else if (eng_done) begin
          wait_d = 1'b0;
          ph_d   = nxt;
          idx_d  = (nxt == ph_q) ? idx_q + CW'(1) : '0;
          if (abort) err_d = 1'b1;
          if (ph_q == PH_RXCNT) rln_d = rcnt;
          if (ph_q == PH_RX && op_q != SM_BLKR) begin
            if (idx_q[0]) rdd_d[15:8] = eng_rbyte;
            else          rdd_d[7:0]  = eng_rbyte;
          end
        end
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ph_q <= PH_IDLE; op_q <= SM_QUICK; wait_q <= 1'b0; rd_q <= 1'b0;
      addr_q <= '0; cmd_q <= '0; dat_q <= '0; len_q <= '0;
      idx_q <= '0; err_q <= 1'b0; rdd_q <= '0; rln_q <= '0;
    end else begin
      ph_q <= ph_d; op_q <= op_d; wait_q <= wait_d; rd_q <= rd_d;
      addr_q <= addr_d; cmd_q <= cmd_d; dat_q <= dat_d; len_q <= len_d;
      idx_q <= idx_d; err_q <= err_d; rdd_q <= rdd_d; rln_q <= rln_d;
    end
  end

  // block buffer: host port while idle, sequencer during block read
  assign host_we   = (ph_q == PH_IDLE) && buf_we;
  assign seq_we    = (ph_q == PH_RX) && step && (op_q == SM_BLKR);
  assign mem_we    = host_we || seq_we;
  assign mem_waddr = seq_we ? idx_q[AW-1:0] : buf_widx;
  assign mem_wdata = seq_we ? eng_rbyte : buf_wdata;

  smbus_seq_buf #(.DEPTH(BUF_DEPTH), .DW(8)) u_buf (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .ra_addr (buf_ridx),
    .ra_data (buf_rdata),
    .rb_addr (idx_q[AW-1:0]),
    .rb_data (blk_byte)
  );

  // engine request
  always_comb begin
    eng_op_w  = ENG_STOP;
    eng_wbyte = '0;
    case (ph_q)
      PH_ADDR: begin
        eng_op_w  = ENG_START;
        eng_wbyte = {addr_q, (op_q == SM_RECV) || (op_q == SM_QUICK && rd_q)};
      end
      PH_RSTART: begin
        eng_op_w  = ENG_START;
        eng_wbyte = {addr_q, 1'b1};
      end
      PH_CMD: begin
        eng_op_w  = ENG_SEND;
        eng_wbyte = cmd_q;
      end
      PH_CNT: begin
        eng_op_w  = ENG_SEND;
        eng_wbyte = 8'(len_q);
      end
      PH_WR: begin
        eng_op_w = ENG_SEND;
        case (op_q)
          SM_WRW:  eng_wbyte = idx_q[0] ? dat_q[15:8] : dat_q[7:0];
          SM_BLKW: eng_wbyte = blk_byte;
          default: eng_wbyte = dat_q[7:0];
        endcase
      end
      PH_RXCNT, PH_RX: eng_op_w = ENG_RECV;
      PH_NACK:         eng_op_w = ENG_NACK;
      default:         eng_op_w = ENG_STOP;
    endcase
  end

  assign eng_op    = eng_op_w;
  assign eng_valid = !wait_q && (ph_q != PH_IDLE) && (ph_q != PH_DONE);
  assign busy      = (ph_q != PH_IDLE);
  assign done      = (ph_q == PH_DONE);
  assign err       = err_q;
  assign rd_data   = rdd_q;
  assign rd_len    = rln_q;

endmodule

// File: rtl/smbus_seq_chk.sv
module smbus_seq_chk #(
  parameter  int BUF_DEPTH = 32,
  localparam int CW        = $clog2(BUF_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [CW-1:0] rd_len,
  input logic          eng_valid
);

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |=> !eng_valid); // R2

  AST_ENG_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |-> (busy && !done)); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R10

  AST_ACCEPT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid)); // R1

  AST_BLOCK_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_len <= CW'(BUF_DEPTH))); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(err)); // R10

endmodule

bind smbus_seq smbus_seq_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .rd_len    (rd_len),
  .eng_valid (eng_valid)
);

// File: tb/smbus_seq_test.sv
module smbus_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        req_valid, req_rd;
  logic [3:0]  req_op;
  logic [6:0]  req_addr;
  logic [7:0]  req_cmd, req_len;
  logic [15:0] req_data;
  logic        buf_we;
  logic [4:0]  buf_widx, buf_ridx;
  logic [7:0]  buf_wdata, buf_rdata;
  logic        busy, done, err;
  logic [15:0] rd_data;
  logic [5:0]  rd_len;
  logic        eng_valid;
  logic [2:0]  eng_op;
  logic [7:0]  eng_wbyte;
  logic        eng_done, eng_nak;
  logic [7:0]  eng_rbyte;

  smbus_seq uut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;

  // engine model state
  int log_q [128];
  int log_n = 0, pend = 0, rx_i = 0, cur_idx = 0, cur_op = 0, viol = 0;
  int nak_t = -1;
  logic [7:0] rx_q [64];
  logic [7:0] hb [32];

  // expected model state
  int exp_q [128];
  int exp_n, xr;
  bit ab, e_err;
  logic [15:0] e_rdd;
  int e_len;
  logic [7:0] e_blk [32];

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (eng_done) begin eng_done = 1'b0; eng_nak = 1'b0; end
    if (pend > 0) begin
      if (eng_valid) viol++;
      pend--;
      if (pend == 0) begin
        eng_done = 1'b1;
        eng_nak  = (cur_idx == nak_t);
        if (cur_op == 2) begin eng_rbyte = rx_q[rx_i]; rx_i++; end
      end
    end else if (eng_valid) begin
      cur_idx = log_n;
      cur_op  = int'(eng_op);
      log_q[log_n] = int'(eng_op) * 256 + ((eng_op <= 3'd1) ? int'(eng_wbyte) : 0);
      log_n++;
      pend = 1 + int'($urandom % 3);
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic e_push(int c); exp_q[exp_n] = c; exp_n++; endtask
  task automatic e_start(logic [7:0] b);
    if (!ab) begin e_push(b); if (exp_n - 1 == nak_t) ab = 1; end
  endtask
  task automatic e_send(logic [7:0] b);
    if (!ab) begin e_push(256 + b); if (exp_n - 1 == nak_t) ab = 1; end
  endtask
  task automatic e_recv(output logic [7:0] b);
    b = 8'h00;
    if (!ab) begin e_push(512); b = rx_q[xr]; xr++; end
  endtask

  task automatic build(int op, bit rd, logic [6:0] a, logic [7:0] c,
                       logic [15:0] d, logic [7:0] len);
    logic [7:0] b, b2;
    int n;
    bit rdop = 0;
    exp_n = 0; ab = 0; xr = 0; e_err = 0; e_rdd = 0; e_len = 0;
    case (op)
      0: e_start({a, rd});
      1: begin e_start({a, 1'b0}); e_send(d[7:0]); end
      2: begin e_start({a, 1'b1}); e_recv(b); e_rdd = {8'h00, b}; rdop = 1; end
      3, 4: begin
        e_start({a, 1'b0}); e_send(c); e_send(d[7:0]);
        if (op == 4) e_send(d[15:8]);
      end
      5, 6: begin
        e_start({a, 1'b0}); e_send(c); e_start({a, 1'b1});
        e_recv(b); e_rdd = {8'h00, b};
        if (op == 6) begin e_recv(b2); e_rdd[15:8] = b2; end
        rdop = 1;
      end
      7: begin
        n = (len > 8'd32) ? 32 : int'(len);
        e_start({a, 1'b0}); e_send(c); e_send(8'(n));
        for (int i = 0; i < n; i++) e_send(hb[i]);
      end
      8: begin
        e_start({a, 1'b0}); e_send(c); e_start({a, 1'b1});
        e_recv(b);
        n = (b > 8'd32) ? 0 : int'(b);
        if (!ab) begin
          e_len = n;
          for (int i = 0; i < n; i++) e_recv(e_blk[i]);
        end
        rdop = 1;
      end
      default: begin e_err = 1; return; end
    endcase
    if (ab) begin e_push(4 * 256); e_err = 1; end
    else begin
      if (rdop) e_push(3 * 256);
      e_push(4 * 256);
    end
  endtask

  function automatic string optag(int op);
    case (op)
      0: return "R3";
      1, 2: return "R4";
      3, 4: return "R5";
      5, 6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic fill_buf();
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      buf_we = 1'b1; buf_widx = 5'(i); buf_wdata = 8'($urandom); hb[i] = buf_wdata;
    end
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic run(int op, bit rd, logic [6:0] a, logic [7:0] c, logic [15:0] d,
                     logic [7:0] len, int nak, bit poke);
    int waits = 0;
    int mism = -1;
    string tg = optag(op);
    nak_t = nak;
    build(op, rd, a, c, d, len);
    log_n = 0; rx_i = 0; viol = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 4'(op); req_rd = rd; req_addr = a;
    req_cmd = c; req_data = d; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      req_valid = 1'b1; req_op = 4'd0; req_addr = ~a;
      buf_we = 1'b1; buf_widx = 5'd0; buf_wdata = ~hb[0];
      @(negedge clk);
      req_valid = 1'b0; buf_we = 1'b0;
    end
    while (!done && waits < 3000) begin @(negedge clk); waits++; end
    chk(done == 1'b1, "R10", "done seen", int'(done), 1);
    if (op > 8) chk(waits == 0 && log_n == 0, "R11", "immediate finish", waits + log_n, 0);
    chk(log_n == exp_n, tg, "operation count", log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (mism < 0 && log_q[i] != exp_q[i]) mism = i;
    chk(mism < 0, poke ? "R12" : tg, "operation sequence",
        (mism < 0) ? 0 : log_q[mism], (mism < 0) ? 0 : exp_q[mism]);
    chk(viol == 0, "R2", "issue while outstanding", viol, 0);
    chk(err == e_err, (nak >= 0) ? "R9" : tg, "err", int'(err), int'(e_err));
    if (!e_err && (op == 2 || op == 5 || op == 6))
      chk(rd_data == e_rdd, tg, "rd_data", int'(rd_data), int'(e_rdd));
    if (!e_err && op == 8) begin
      chk(int'(rd_len) == e_len, "R8", "rd_len", int'(rd_len), e_len);
      for (int i = 0; i < e_len; i++) begin
        buf_ridx = 5'(i); #1;
        chk(buf_rdata == e_blk[i], "R8", "block byte", int'(buf_rdata), int'(e_blk[i]));
        hb[i] = e_blk[i];
      end
    end
    @(negedge clk);
    chk(!done && !busy, "R10", "done single pulse", int'(done) + int'(busy), 0);
    @(negedge clk);
    chk(err == e_err, "R10", "err held", int'(err), int'(e_err));
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_rd = 1'b0; req_addr = '0;
    req_cmd = '0; req_data = '0; req_len = '0; buf_we = 1'b0; buf_widx = '0;
    buf_wdata = '0; buf_ridx = '0; eng_done = 1'b0; eng_nak = 1'b0; eng_rbyte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !eng_valid && !err, "R1", "reset state",
        int'({busy, done, eng_valid, err}), 0);
    fill_buf();

    // directed cases
    run(0, 1'b1, 7'h50, 8'h00, 16'h0000, 8'd0, -1, 1'b0);           // R3 quick read
    run(0, 1'b0, 7'h22, 8'h00, 16'h0000, 8'd0, -1, 1'b0);           // R3 quick write
    run(1, 1'b0, 7'h11, 8'h00, 16'h00C3, 8'd0, -1, 1'b0);           // R4 send byte
    rx_q[0] = 8'h9A;
    run(2, 1'b0, 7'h12, 8'h00, 16'h0000, 8'd0, -1, 1'b0);           // R4 receive byte
    run(4, 1'b0, 7'h33, 8'h07, 16'hA55A, 8'd0, -1, 1'b0);           // R5 word order
    rx_q[0] = 8'h34; rx_q[1] = 8'h12;
    run(6, 1'b0, 7'h34, 8'h08, 16'h0000, 8'd0, -1, 1'b0);           // R6 word read
    run(7, 1'b0, 7'h40, 8'h20, 16'h0000, 8'd40, -1, 1'b0);          // R7 clamp to 32
    run(7, 1'b0, 7'h40, 8'h21, 16'h0000, 8'd0, -1, 1'b0);           // R7 zero length
    rx_q[0] = 8'd33;
    run(8, 1'b0, 7'h41, 8'h22, 16'h0000, 8'd0, -1, 1'b0);           // R8 count 33 -> 0
    rx_q[0] = 8'd32;
    for (int i = 1; i <= 32; i++) rx_q[i] = 8'(i * 7);
    run(8, 1'b0, 7'h41, 8'h23, 16'h0000, 8'd0, -1, 1'b0);           // R8 full count
    run(3, 1'b0, 7'h60, 8'h01, 16'h0055, 8'd0, 0, 1'b0);            // R9 address refused
    run(4, 1'b0, 7'h61, 8'h02, 16'h1234, 8'd0, 2, 1'b0);            // R9 low byte refused
    rx_q[0] = 8'h77;
    run(5, 1'b0, 7'h62, 8'h03, 16'h0000, 8'd0, 3, 1'b0);            // R9 nak on RECV ignored
    run(12, 1'b0, 7'h63, 8'h04, 16'h0000, 8'd0, -1, 1'b0);          // R11 bad code
    run(7, 1'b0, 7'h64, 8'h05, 16'h0000, 8'd8, -1, 1'b1);           // R1 R12 busy pokes

    // random mix
    for (int t = 0; t < 80; t++) begin
      int op, nk;
      op = (($urandom % 10) == 0) ? 9 + int'($urandom % 7) : int'($urandom % 9);
      nk = (($urandom % 4) == 0) ? int'($urandom % 8) : -1;
      for (int i = 0; i < 64; i++) rx_q[i] = 8'($urandom);
      rx_q[0] = 8'($urandom % 40);
      if (op == 7 && ($urandom % 2) == 1) fill_buf();
      run(op, 1'($urandom), 7'($urandom), 8'($urandom), 16'($urandom),
          8'($urandom % 40), nk, 1'b0);
    end

    finish_run();
  end

endmodule